// File: doc/BRIEF.md
# Conversion and Modulator Fault Monitor

This block sits beside the conversion path of an oversampling converter and watches it for three classes of fault. It counts how many identical bits in a row arrive from the one-bit modulator. When that run reaches a set length, it raises a saturation flag. It also receives the raw conversion result together with two comparison inputs. These inputs say whether the gain-scaled input is above positive full scale or below negative full scale. An out-of-range result is replaced by a forced all-ones or all-zeros code, and a range flag is raised.

The block also owns the offset and gain calibration registers. The external calibration logic reports that a run has finished and whether it succeeded. On success the new coefficients are loaded. On failure the stored coefficients are left as they were and a calibration error flag is raised. Every flag stays set until the host pulses the clear input. The reset input is asynchronous and active low, and its release is synchronised to the clock inside the block.

Top module: `conv_fault_monitor`

## Requirements
- R1: A strobed bit counts towards a run only when `mod_bit_vld` is high. After RUN_LEN consecutive strobed bits of the same value (either ones or zeros), `sat_flag` is high in the cycle after the strobe of the last of those bits. A run of RUN_LEN-1 bits leaves it low.
- R2: A strobed bit that differs from the previous strobed bit restarts the run count at one. Cycles without `mod_bit_vld` neither extend nor break a run, whatever value `mod_bit` has in them. The run counter stops at RUN_LEN and does not wrap.
- R3: A result strobed with `above_fs` high appears on `res_out` as all ones (0xFFFFFF for 24 bits), and `ovr_flag` is set.
- R4: A result strobed with `below_fs` high and `above_fs` low appears as all zeros (0x000000), and `udr_flag` is set. When both comparison inputs are high, the over-range handling of R3 applies and `udr_flag` is not set.
- R5: A result strobed with both comparison inputs low passes to `res_out` unchanged and sets no flag.
- R6: A `cal_done` pulse with `cal_pass` high loads `cal_offset_in` into `offset_coef` and `cal_gain_in` into `gain_coef`, visible in the next cycle.
- R7: A `cal_done` pulse with `cal_pass` low sets `cal_err_flag` and leaves `offset_coef` and `gain_coef` unchanged.
- R8: `res_out_vld` is high exactly one cycle after each `res_vld` strobe. Between strobes, `res_out` holds its last value.
- R9: Every flag is sticky until `flag_clr` is pulsed. If a new fault arrives in the same cycle as the clear, the flag stays set.
- R10: After reset, all flags, `res_out` and `res_out_vld` are zero, `offset_coef` is zero and `gain_coef` equals GAIN_RST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_bit_vld | input | 1 | Strobe marking a valid modulator bit |
| mod_bit | input | 1 | Modulator output bit |
| res_vld | input | 1 | Strobe marking a valid raw result |
| res_raw | input | RESULT_W | Raw conversion result |
| above_fs | input | 1 | Gain-scaled input is above positive full scale |
| below_fs | input | 1 | Gain-scaled input is below negative full scale |
| cal_done | input | 1 | Calibration run has finished (one-cycle pulse) |
| cal_pass | input | 1 | Calibration run succeeded, qualified by cal_done |
| cal_offset_in | input | COEF_W | Offset coefficient from calibration |
| cal_gain_in | input | COEF_W | Gain coefficient from calibration |
| flag_clr | input | 1 | Host pulse that clears all sticky flags |
| res_out | output | RESULT_W | Result, clamped when out of range |
| res_out_vld | output | 1 | Result strobe, one cycle after res_vld |
| offset_coef | output | COEF_W | Stored offset coefficient |
| gain_coef | output | COEF_W | Stored gain coefficient |
| sat_flag | output | 1 | Sticky modulator saturation flag |
| ovr_flag | output | 1 | Sticky over-range flag |
| udr_flag | output | 1 | Sticky under-range flag |
| cal_err_flag | output | 1 | Sticky calibration failure flag |

## Verification
The bench builds the block with its defaults: RUN_LEN of 20, 24-bit results and 24-bit coefficients. With these values, the forced codes 0xFFFFFF and 0x000000 are the exact ones named in R3 and R4. The bench drives randomly drawn run lengths from 1 to 25 bits. This makes runs just short of the threshold, runs exactly at it and runs well past it all frequent, so that the saturating counter and the re-setting of the flag after a clear are both exercised.

// File: rtl/conv_fault_pkg.sv
package conv_fault_pkg;

  // Sticky fault flags kept by the monitor, in a fixed report order.
  typedef struct packed {
    logic sat;
    logic ovr;
    logic udr;
    logic cal;
  } fault_flags_t;

  localparam int unsigned FLAG_COUNT = $bits(fault_flags_t);

  // Width of a counter that must be able to hold the value lim.
  function automatic int unsigned cnt_width(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/conv_rst_sync.sv
module conv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/conv_run_detector.sv
module conv_run_detector
  import conv_fault_pkg::*;
#(
  parameter int unsigned RUN_LEN = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bit_vld,
  input  logic bit_val,
  output logic sat_o
);

  localparam int unsigned CNT_W = cnt_width(RUN_LEN);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last_q, last_d;
  logic             sat_q, sat_d;
  logic             run_en;
  logic             hit;

  // Next-state logic: restart on a change, stop at the threshold.
  always_comb begin
    cnt_d  = cnt_q;
    last_d = last_q;
    if (bit_vld) begin
      if ((cnt_q == '0) || (bit_val != last_q)) begin
        cnt_d  = CNT_ONE;
        last_d = bit_val;
      end else if (cnt_q < CNT_MAX) begin
        cnt_d = cnt_q + CNT_ONE;
      end
    end
  end

  assign run_en = bit_vld;
  assign hit    = bit_vld && (cnt_d == CNT_MAX);
  assign sat_d  = hit | (sat_q & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= 1'b0;
    end else if (run_en) begin
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sat_q <= 1'b0;
    end else begin
      sat_q <= sat_d;
    end
  end

  assign sat_o = sat_q;

  AST_SAT_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_q) |-> $past(bit_vld)); // R1

  AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && (cnt_q != '0) && (bit_val != last_q)) |=> (cnt_q == CNT_ONE)); // R2

  AST_RUN_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX) || (cnt_q == CNT_ONE)); // R2

  AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_q && !clr) |=> sat_q); // R9

endmodule

// File: rtl/conv_range_clamp.sv
module conv_range_clamp #(
  parameter int unsigned RESULT_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                res_vld,
  input  logic [RESULT_W-1:0] res_raw,
  input  logic                above,
  input  logic                below,
  output logic [RESULT_W-1:0] res_o,
  output logic                vld_o,
  output logic                ovr_o,
  output logic                udr_o
);

  localparam logic [RESULT_W-1:0] CODE_HI = {RESULT_W{1'b1}};
  localparam logic [RESULT_W-1:0] CODE_LO = {RESULT_W{1'b0}};

  logic [RESULT_W-1:0] res_q, res_d;
  logic                vld_q;
  logic                ovr_q, ovr_d;
  logic                udr_q, udr_d;
  logic                is_ovr, is_udr;

  // Over-range takes priority when both comparisons are asserted.
  assign is_ovr = res_vld & above;
  assign is_udr = res_vld & below & ~above;

  always_comb begin
    if (above) begin
      res_d = CODE_HI;
    end else if (below) begin
      res_d = CODE_LO;
    end else begin
      res_d = res_raw;
    end
  end

  assign ovr_d = is_ovr | (ovr_q & ~clr);
  assign udr_d = is_udr | (udr_q & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (res_vld) begin
      res_q <= res_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ovr_q <= 1'b0;
      udr_q <= 1'b0;
    end else begin
      vld_q <= res_vld;
      ovr_q <= ovr_d;
      udr_q <= udr_d;
    end
  end

  assign res_o = res_q;
  assign vld_o = vld_q;
  assign ovr_o = ovr_q;
  assign udr_o = udr_q;

  AST_OVR_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && above) |=> ((res_q == CODE_HI) && ovr_q)); // R3

  AST_UDR_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && below && !above) |=> ((res_q == CODE_LO) && udr_q)); // R4

  AST_IN_RANGE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !above && !below) |=> (res_q == $past(res_raw))); // R5

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |=> $stable(res_q)); // R8

  AST_RANGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovr_q || udr_q) && !clr) |=> (ovr_q || udr_q)); // R9

endmodule

// File: rtl/conv_cal_gate.sv
module conv_cal_gate #(
  parameter int unsigned         COEF_W   = 24,
  parameter logic [COEF_W-1:0]   GAIN_RST = 24'h400000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cal_done,
  input  logic              cal_pass,
  input  logic [COEF_W-1:0] off_in,
  input  logic [COEF_W-1:0] gain_in,
  output logic [COEF_W-1:0] off_o,
  output logic [COEF_W-1:0] gain_o,
  output logic              err_o
);

  logic [COEF_W-1:0] off_q, gain_q;
  logic              err_q, err_d;
  logic              load_en;
  logic              fail;

  assign load_en = cal_done &  cal_pass;
  assign fail    = cal_done & ~cal_pass;
  assign err_d   = fail | (err_q & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= '0;
      gain_q <= GAIN_RST;
    end else if (load_en) begin
      off_q  <= off_in;
      gain_q <= gain_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign off_o  = off_q;
  assign gain_o = gain_q;
  assign err_o  = err_q;

  AST_CAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && cal_pass) |=> ((off_q == $past(off_in)) && (gain_q == $past(gain_in)))); // R6

  AST_CAL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && !cal_pass) |=> ($stable(off_q) && $stable(gain_q) && err_q)); // R7

  AST_CAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clr) |=> err_q); // R9

endmodule

// File: rtl/conv_fault_monitor.sv
module conv_fault_monitor
  import conv_fault_pkg::*;
#(
  parameter int unsigned       RUN_LEN  = 20,
  parameter int unsigned       RESULT_W = 24,
  parameter int unsigned       COEF_W   = 24,
  parameter logic [COEF_W-1:0] GAIN_RST = 24'h400000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mod_bit_vld,
  input  logic                mod_bit,
  input  logic                res_vld,
  input  logic [RESULT_W-1:0] res_raw,
  input  logic                above_fs,
  input  logic                below_fs,
  input  logic                cal_done,
  input  logic                cal_pass,
  input  logic [COEF_W-1:0]   cal_offset_in,
  input  logic [COEF_W-1:0]   cal_gain_in,
  input  logic                flag_clr,
  output logic [RESULT_W-1:0] res_out,
  output logic                res_out_vld,
  output logic [COEF_W-1:0]   offset_coef,
  output logic [COEF_W-1:0]   gain_coef,
  output logic                sat_flag,
  output logic                ovr_flag,
  output logic                udr_flag,
  output logic                cal_err_flag
);

  logic         rst_n_int;
  fault_flags_t flags;

  conv_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  conv_run_detector #(.RUN_LEN(RUN_LEN)) u_run (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .clr     (flag_clr),
    .bit_vld (mod_bit_vld),
    .bit_val (mod_bit),
    .sat_o   (flags.sat)
  );

  conv_range_clamp #(.RESULT_W(RESULT_W)) u_clamp (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .clr     (flag_clr),
    .res_vld (res_vld),
    .res_raw (res_raw),
    .above   (above_fs),
    .below   (below_fs),
    .res_o   (res_out),
    .vld_o   (res_out_vld),
    .ovr_o   (flags.ovr),
    .udr_o   (flags.udr)
  );

  conv_cal_gate #(.COEF_W(COEF_W), .GAIN_RST(GAIN_RST)) u_cal (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .clr      (flag_clr),
    .cal_done (cal_done),
    .cal_pass (cal_pass),
    .off_in   (cal_offset_in),
    .gain_in  (cal_gain_in),
    .off_o    (offset_coef),
    .gain_o   (gain_coef),
    .err_o    (flags.cal)
  );

  assign sat_flag     = flags.sat;
  assign ovr_flag     = flags.ovr;
  assign udr_flag     = flags.udr;
  assign cal_err_flag = flags.cal;

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n_int)
    res_vld |=> res_out_vld); // R8

  AST_RANGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n_int)
    (res_vld && above_fs && !udr_flag && !flag_clr) |=> !udr_flag); // R4

endmodule

// File: tb/conv_fault_monitor_tb.sv
module conv_fault_monitor_tb;

  localparam int unsigned RUN_LEN  = 20;
  localparam int unsigned RESULT_W = 24;
  localparam int unsigned COEF_W   = 24;
  localparam logic [COEF_W-1:0] GAIN_RST = 24'h400000;
  localparam int unsigned WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mod_bit_vld = 1'b0, mod_bit = 1'b0;
  logic res_vld = 1'b0;
  logic [RESULT_W-1:0] res_raw = '0;
  logic above_fs = 1'b0, below_fs = 1'b0;
  logic cal_done = 1'b0, cal_pass = 1'b0;
  logic [COEF_W-1:0] cal_offset_in = '0, cal_gain_in = '0;
  logic flag_clr = 1'b0;
  logic [RESULT_W-1:0] res_out;
  logic res_out_vld;
  logic [COEF_W-1:0] offset_coef, gain_coef;
  logic sat_flag, ovr_flag, udr_flag, cal_err_flag;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // Reference model state
  int   m_cnt = 0;
  logic m_last = 1'b0;
  logic m_sat = 1'b0, m_ovr = 1'b0, m_udr = 1'b0, m_cal = 1'b0;
  logic [RESULT_W-1:0] m_res = '0;
  logic [COEF_W-1:0] m_off = '0, m_gain = GAIN_RST;

  always #2.5 clk = ~clk;

  conv_fault_monitor #(
    .RUN_LEN(RUN_LEN), .RESULT_W(RESULT_W), .COEF_W(COEF_W), .GAIN_RST(GAIN_RST)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .mod_bit_vld(mod_bit_vld), .mod_bit(mod_bit),
    .res_vld(res_vld), .res_raw(res_raw), .above_fs(above_fs), .below_fs(below_fs),
    .cal_done(cal_done), .cal_pass(cal_pass), .cal_offset_in(cal_offset_in),
    .cal_gain_in(cal_gain_in), .flag_clr(flag_clr), .res_out(res_out),
    .res_out_vld(res_out_vld), .offset_coef(offset_coef), .gain_coef(gain_coef),
    .sat_flag(sat_flag), .ovr_flag(ovr_flag), .udr_flag(udr_flag),
    .cal_err_flag(cal_err_flag)
  );

  function automatic logic [RESULT_W-1:0] exp_result(input logic [RESULT_W-1:0] raw,
                                                     input logic ov, input logic un);
    if (ov) return {RESULT_W{1'b1}};
    if (un) return {RESULT_W{1'b0}};
    return raw;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic send_bit(input logic b, input string req);
    mod_bit_vld = 1'b1;
    mod_bit = b;
    tick();
    mod_bit_vld = 1'b0;
    if (m_cnt == 0 || b != m_last) begin
      m_cnt = 1;
      m_last = b;
    end else if (m_cnt < RUN_LEN) begin
      m_cnt++;
    end
    if (m_cnt >= RUN_LEN) m_sat = 1'b1;
    chk(req, 32'(sat_flag), 32'(m_sat));
  endtask

  task automatic clear_flags();
    flag_clr = 1'b1;
    tick();
    flag_clr = 1'b0;
    m_sat = 1'b0; m_ovr = 1'b0; m_udr = 1'b0; m_cal = 1'b0;
    chk("R9 clear", {28'd0, sat_flag, ovr_flag, udr_flag, cal_err_flag}, 32'd0);
  endtask

  task automatic send_res(input logic [RESULT_W-1:0] raw, input logic ov, input logic un,
                          input string req);
    res_vld = 1'b1; res_raw = raw; above_fs = ov; below_fs = un;
    tick();
    res_vld = 1'b0; above_fs = 1'b0; below_fs = 1'b0; res_raw = ~raw;
    m_res = exp_result(raw, ov, un);
    if (ov) m_ovr = 1'b1;
    if (un && !ov) m_udr = 1'b1;
    chk({req, " result"}, 32'(res_out), 32'(m_res));
    chk("R8 valid strobe", 32'(res_out_vld), 32'd1);
    chk({req, " ovr_flag"}, 32'(ovr_flag), 32'(m_ovr));
    chk({req, " udr_flag"}, 32'(udr_flag), 32'(m_udr));
    tick();
    chk("R8 valid drop", 32'(res_out_vld), 32'd0);
    chk("R8 result hold", 32'(res_out), 32'(m_res));
  endtask

  task automatic do_cal(input logic pass, input logic [COEF_W-1:0] off,
                        input logic [COEF_W-1:0] gn, input string req);
    cal_done = 1'b1; cal_pass = pass; cal_offset_in = off; cal_gain_in = gn;
    tick();
    cal_done = 1'b0; cal_pass = 1'b0; cal_offset_in = ~off; cal_gain_in = ~gn;
    if (pass) begin
      m_off = off; m_gain = gn;
    end else begin
      m_cal = 1'b1;
    end
    chk({req, " offset"}, 32'(offset_coef), 32'(m_off));
    chk({req, " gain"}, 32'(gain_coef), 32'(m_gain));
    chk({req, " cal_err_flag"}, 32'(cal_err_flag), 32'(m_cal));
  endtask

  // Watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) tick();
    chk("R10 reset sat", 32'(sat_flag), 32'd0);
    rst_n = 1'b1;
    repeat (3) tick();
    // R10: reset state
    chk("R10 flags", {28'd0, sat_flag, ovr_flag, udr_flag, cal_err_flag}, 32'd0);
    chk("R10 res_out", 32'(res_out), 32'd0);
    chk("R10 res_out_vld", 32'(res_out_vld), 32'd0);
    chk("R10 offset", 32'(offset_coef), 32'd0);
    chk("R10 gain", 32'(gain_coef), 32'(GAIN_RST));

    // R1: ones run, threshold exactly
    for (int i = 0; i < RUN_LEN - 1; i++) send_bit(1'b1, "R1 ones below threshold");
    chk("R1 no sat at RUN_LEN-1", 32'(sat_flag), 32'd0);
    send_bit(1'b1, "R1 ones at threshold");
    chk("R1 sat after ones", 32'(sat_flag), 32'd1);
    // R9: sticky over idle cycles
    repeat (5) tick();
    chk("R9 sat sticky", 32'(sat_flag), 32'd1);
    clear_flags();

    // R2: change restarts the run; zeros run
    send_bit(1'b0, "R2 change restarts");
    for (int i = 0; i < RUN_LEN - 2; i++) send_bit(1'b0, "R2 zeros below");
    chk("R2 no sat after restart", 32'(sat_flag), 32'd0);
    send_bit(1'b1, "R2 break run");
    for (int i = 0; i < RUN_LEN - 1; i++) send_bit(1'b0, "R2 zeros rebuild");
    chk("R2 zeros RUN_LEN-1", 32'(sat_flag), 32'd0);
    send_bit(1'b0, "R1 zeros at threshold");
    chk("R1 sat after zeros", 32'(sat_flag), 32'd1);
    clear_flags();

    // R2: unstrobed cycles ignored
    send_bit(1'b1, "R2 restart");
    for (int i = 0; i < RUN_LEN / 2 - 1; i++) send_bit(1'b1, "R2 first half");
    for (int i = 0; i < 8; i++) begin
      mod_bit = i[0];
      tick();
    end
    chk("R2 idle no effect", 32'(sat_flag), 32'd0);
    for (int i = 0; i < RUN_LEN - RUN_LEN / 2; i++) send_bit(1'b1, "R2 second half");
    chk("R2 run across idle", 32'(sat_flag), 32'd1);
    // R2 saturating counter: keep going, clear, next equal bit re-sets
    for (int i = 0; i < 10; i++) send_bit(1'b1, "R2 past threshold");
    clear_flags();
    send_bit(1'b1, "R2 no wrap re-set");
    chk("R2 saturated counter re-sets", 32'(sat_flag), 32'd1);
    clear_flags();

    // Random runs
    for (int r = 0; r < 300; r++) begin
      logic b;
      int len;
      b = 1'($urandom);
      len = 1 + ($urandom % 25);
      for (int k = 0; k < len; k++) begin
        if (($urandom % 8) == 0) tick();
        send_bit(b, "R1 random runs");
      end
      if (($urandom % 4) == 0) clear_flags();
    end
    clear_flags();

    // Result path directed
    send_res(24'h123456, 1'b0, 1'b0, "R5 in range");
    chk("R5 no flag", {30'd0, ovr_flag, udr_flag}, 32'd0);
    send_res(24'h0000FF, 1'b1, 1'b0, "R3 over range");
    chk("R3 forced ones", 32'(res_out), 32'h00FFFFFF);
    clear_flags();
    send_res(24'hABCDEF, 1'b0, 1'b1, "R4 under range");
    chk("R4 forced zeros", 32'(res_out), 32'd0);
    clear_flags();
    send_res(24'h555555, 1'b1, 1'b1, "R4 both high over wins");
    chk("R4 both: udr clear", 32'(udr_flag), 32'd0);
    // R9 set wins over clear in same cycle
    flag_clr = 1'b1;
    res_vld = 1'b1; res_raw = 24'h1; above_fs = 1'b1;
    tick();
    flag_clr = 1'b0; res_vld = 1'b0; above_fs = 1'b0;
    m_res = {RESULT_W{1'b1}};
    chk("R9 set wins over clear", 32'(ovr_flag), 32'd1);
    clear_flags();

    // Random results
    for (int i = 0; i < 200; i++) begin
      logic [RESULT_W-1:0] raw;
      int sel;
      raw = RESULT_W'($urandom);
      sel = $urandom % 8;
      send_res(raw, sel == 0 || sel == 2, sel == 1 || sel == 2, "R3 R4 R5 random");
      if (sel == 7) clear_flags();
    end
    clear_flags();

    // Calibration
    do_cal(1'b1, 24'h000123, 24'h3FF000, "R6 pass load");
    do_cal(1'b0, 24'h777777, 24'h111111, "R7 fail hold");
    tick();
    chk("R9 cal_err sticky", 32'(cal_err_flag), 32'd1);
    clear_flags();
    for (int i = 0; i < 40; i++) begin
      logic p;
      p = 1'($urandom);
      do_cal(p, COEF_W'($urandom), COEF_W'($urandom), p ? "R6 random" : "R7 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule